// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit gathers the twelve event sources of an I2C controller into one raw status word, filters that word through a software mask, and drives a single registered interrupt line. Software finds the cause of an interrupt by reading the raw or the masked status. It then acknowledges individual causes by reading a dedicated clear address for each source. Because each clear touches only one bit, an event that arrives between the status read and the acknowledge is not lost. A combined clear address acknowledges every latched cause in one read.

A second word records why a transmit was abandoned, for example a missing acknowledge, lost arbitration, or an illegal START byte or general-call use. Cause bits accumulate until the transmit-abort status is acknowledged, and that acknowledge also wipes them. Two of the sources, receive-FIFO-full and transmit-FIFO-empty, are live conditions and not latched events. Reads cannot clear them.

Top module: `isr_status_unit`

## Requirements
- R1: A one-cycle high on `src_i[i]` at a latched position sets raw status bit i at the next clock edge. The bit positions are: rx_under 0, rx_over 1, rx_full 2, tx_over 3, tx_empty 4, rd_req 5, tx_abrt 6, rx_done 7, activity 8, stop_det 9, start_det 10, gen_call 11. A read at address 0 returns the raw status in bits 11:0.
- R2: A cycle with `mask_we_i` high loads `mask_wdata_i` into the mask. Address 2 returns the mask, and address 1 returns raw status AND mask.
- R3: A read at address 8+i returns raw bit i in bit 0. For a latched source it clears only bit i at that clock edge.
- R4: A read at address 4 returns the raw status and clears every latched raw bit at that clock edge.
- R5: When a source event and a clear of the same bit fall in the same cycle, the event wins and the bit stays set.
- R6: Raw bits 2 and 4 follow `src_i[2]` and `src_i[4]` as levels in the same cycle, and no clear read changes them.
- R7: `irq_o` equals the OR of (raw status AND mask) as seen in the previous cycle.
- R8: In each cycle, `abrt_cause_i` is ORed into the abort cause word, which address 3 returns. Only positions 0-5, 7 and 9-12 are kept, so bits 6, 8 and 13 and above always read zero.
- R9: A read at address 14 (the tx_abrt clear) or at address 4 zeroes the abort cause word. Cause bits that arrive in that same cycle are still kept.
- R10: After reset, the raw latched bits, the mask, the abort cause word and `irq_o` are all zero.
- R11: Reads at addresses 5, 6, 7 and 20 and above return zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 12 | Event pulses (latched positions) and FIFO levels (positions 2 and 4) |
| abrt_cause_i | input | 13 | Transmit-abort cause pulses |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 12 | New mask value |
| rd_en_i | input | 1 | Read strobe; clear side effects happen at the edge |
| rd_addr_i | input | ADDR_W (5) | Read address |
| rd_data_o | output | DATA_W (16) | Read data for `rd_addr_i`, valid in the same cycle |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The bench builds the unit with its default parameters, ADDR_W=5 and DATA_W=16. With a 5-bit address, every one of the 32 locations can be reached. This includes the unused gaps between the status words and the per-source clears, and the locations above address 19. Random reads therefore exercise both the decoded and the undecoded locations. The 16-bit data word is wide enough to show all 13 cause positions and the reserved zero bits above them.

// File: rtl/isr_pkg.sv
// Shared constants for the interrupt status unit: source count, level-source
// positions, abort-cause keep mask and the read address map.
package isr_pkg;
    localparam int NSRC        = 12;
    localparam int ABRT_W      = 13;
    localparam int SRC_RX_FULL = 2;
    localparam int SRC_TX_EMPTY = 4;
    localparam int SRC_TX_ABRT = 6;

    // Sources that follow a FIFO level instead of latching an event.
    localparam logic [NSRC-1:0] LEVEL_SRCS =
        (NSRC'(1) << SRC_RX_FULL) | (NSRC'(1) << SRC_TX_EMPTY);

    // Abort cause positions that exist; all others are held at zero.
    localparam logic [ABRT_W-1:0] ABRT_KEEP = 13'h1EBF;

    // Read address map.
    localparam int ADR_RAW      = 0;
    localparam int ADR_MASKED   = 1;
    localparam int ADR_MASK     = 2;
    localparam int ADR_CAUSE    = 3;
    localparam int ADR_CLR_ALL  = 4;
    localparam int ADR_CLR_BASE = 8;
endpackage

// File: rtl/isr_raw_bank.sv
// Raw status bank. One slice per source. A latched slice is set by a source
// pulse and cleared by a read of its own clear address or of the combined
// clear address, and the pulse takes priority over the clear. A level slice
// passes the FIFO condition straight through.
// Assumes: a read clears only when rd_en_i is high at the clock edge.
module isr_raw_bank
    import isr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [NSRC-1:0]   raw_o
);
    logic clr_all;
    int   sel;

    // Decode the combined clear once for all slices.
    assign sel     = int'(rd_addr_i);
    assign clr_all = rd_en_i && (sel == ADR_CLR_ALL);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (LEVEL_SRCS[i]) begin : g_lvl
            assign raw_o[i] = src_i[i];
        end else begin : g_lat
            logic q;
            logic clr_me;
            assign clr_me = clr_all || (rd_en_i && (sel == ADR_CLR_BASE + i));
            // Latch the event; an event in the same cycle beats a clear.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= src_i[i] | (q & ~clr_me);
            end
            assign raw_o[i] = q;
        end
    end
endmodule

// File: rtl/isr_abort_latch.sv
// Abort cause accumulator. Cause pulses are ORed in at the positions that
// exist. A wipe request empties the word, but causes that arrive in the
// same cycle survive.
// Assumes: wipe_i is already qualified with the read strobe.
module isr_abort_latch
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ABRT_W-1:0] cause_i,
    input  logic              wipe_i,
    output logic [ABRT_W-1:0] cause_o
);
    logic [ABRT_W-1:0] cause_q;

    // Accumulate the causes, or restart from new causes on a wipe.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (wipe_i ? '0 : cause_q) | (cause_i & ABRT_KEEP);
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/isr_read_mux.sv
// Read data selection. Purely combinational: it returns the value in
// front of any clear that the same read causes at the clock edge.
// Assumes: DATA_W >= ABRT_W and DATA_W >= NSRC.
module isr_read_mux
    import isr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [NSRC-1:0]   raw_i,
    input  logic [NSRC-1:0]   mask_i,
    input  logic [ABRT_W-1:0] cause_i,
    output logic [DATA_W-1:0] rd_data_o
);
    int sel;
    assign sel = int'(rd_addr_i);

    // Pick one word by address; undecoded addresses read zero.
    always_comb begin
        rd_data_o = '0;
        if (sel == ADR_RAW || sel == ADR_CLR_ALL)
            rd_data_o[NSRC-1:0] = raw_i;
        else if (sel == ADR_MASKED)
            rd_data_o[NSRC-1:0] = raw_i & mask_i;
        else if (sel == ADR_MASK)
            rd_data_o[NSRC-1:0] = mask_i;
        else if (sel == ADR_CAUSE)
            rd_data_o[ABRT_W-1:0] = cause_i;
        else if (sel >= ADR_CLR_BASE && sel < ADR_CLR_BASE + NSRC)
            rd_data_o[0] = raw_i[sel - ADR_CLR_BASE];
    end
endmodule

// File: rtl/isr_status_unit.sv
// Top of the interrupt status unit. It holds the mask register and the
// registered interrupt, and it connects the raw bank, the abort latch and
// the read mux.
// Assumes: a single read port, with the mask written through a separate strobe.
module isr_status_unit
    import isr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ABRT_W-1:0] abrt_cause_i,
    input  logic              mask_we_i,
    input  logic [NSRC-1:0]   mask_wdata_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [NSRC-1:0]   raw_w;
    logic [NSRC-1:0]   mask_q;
    logic [ABRT_W-1:0] cause_w;
    logic              wipe_w;
    logic              irq_q;
    int                sel;

    assign sel    = int'(rd_addr_i);
    assign wipe_w = rd_en_i && (sel == ADR_CLR_ALL || sel == ADR_CLR_BASE + SRC_TX_ABRT);

    isr_raw_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .raw_o(raw_w)
    );

    isr_abort_latch u_abrt (
        .clk(clk), .rst_n(rst_n), .cause_i(abrt_cause_i),
        .wipe_i(wipe_w), .cause_o(cause_w)
    );

    isr_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .rd_addr_i(rd_addr_i), .raw_i(raw_w), .mask_i(mask_q),
        .cause_i(cause_w), .rd_data_o(rd_data_o)
    );

    // Mask register, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    // Combined interrupt, registered once from the masked status.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(raw_w & mask_q);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/isr_status_chk.sv
// Property checker for isr_status_unit, attached through bind below.
module isr_status_chk
    import isr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic [NSRC-1:0]   src_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [ABRT_W-1:0] cause_in_i,
    input logic [NSRC-1:0]   raw_i,
    input logic [NSRC-1:0]   mask_i,
    input logic [ABRT_W-1:0] cause_q_i,
    input logic              irq_i
);
    int   sel;
    logic clr_all;
    logic wipe;
    assign sel     = int'(rd_addr_i);
    assign clr_all = rd_en_i && sel == ADR_CLR_ALL;
    assign wipe    = clr_all || (rd_en_i && sel == ADR_CLR_BASE + SRC_TX_ABRT);

    p_irq_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        1'b1 |=> (irq_i == $past(|(raw_i & mask_i))));

    p_cause_wipe_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wipe && cause_in_i == '0) |=> (cause_q_i == '0));

    p_cause_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !wipe |=> ((cause_q_i & $past(cause_q_i)) == $past(cause_q_i)));

    p_cause_reserved_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        1'b1 |-> ((cause_q_i & ~ABRT_KEEP) == '0));

    p_level_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        clr_all |=> (raw_i[SRC_RX_FULL] == src_i[SRC_RX_FULL] &&
                     raw_i[SRC_TX_EMPTY] == src_i[SRC_TX_EMPTY]));

    for (genvar i = 0; i < NSRC; i++) begin : g_lat
        if (!LEVEL_SRCS[i]) begin : g_chk
            logic clr_me;
            assign clr_me = clr_all || (rd_en_i && sel == ADR_CLR_BASE + i);

            p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                src_i[i] |=> raw_i[i]);
            p_event_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                (src_i[i] && clr_me) |=> raw_i[i]);
            p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                (clr_me && !src_i[i]) |=> !raw_i[i]);
            p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                (raw_i[i] && !clr_me) |=> raw_i[i]);
            p_no_spont_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
                (!raw_i[i] && !src_i[i]) |=> !raw_i[i]);
        end
    end
endmodule

bind isr_status_unit isr_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i(clk), .rst_n_i(rst_n), .src_i(src_i), .rd_en_i(rd_en_i),
    .rd_addr_i(rd_addr_i), .cause_in_i(abrt_cause_i), .raw_i(raw_w),
    .mask_i(mask_q), .cause_q_i(cause_w), .irq_i(irq_o)
);

// File: tb/sim_isr_status_unit.sv
`timescale 1ns/1ps
module sim_isr_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src = '0;
    logic [12:0] cause = '0;
    logic        mask_we = 1'b0;
    logic [11:0] mask_wd = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;

    always #5 clk = ~clk;

    isr_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .abrt_cause_i(cause),
        .mask_we_i(mask_we), .mask_wdata_i(mask_wd), .rd_en_i(rd_en),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    // Reference state, kept as plain bits and integers.
    bit [11:0] m_lat;
    bit [11:0] m_mask;
    bit [12:0] m_cause;
    bit        m_irq;
    bit [11:0] level_bits;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic bit is_level(int i);
        return (i == 2) || (i == 4);
    endfunction

    function automatic bit [11:0] view();
        bit [11:0] v;
        for (int i = 0; i < 12; i++) v[i] = is_level(i) ? src[i] : m_lat[i];
        return v;
    endfunction

    function automatic bit [15:0] exp_data(int a);
        bit [11:0] v = view();
        if (a == 0 || a == 4) return {4'b0, v};
        if (a == 1) return {4'b0, v & m_mask};
        if (a == 2) return {4'b0, m_mask};
        if (a == 3) return {3'b0, m_cause};
        if (a >= 8 && a < 20) return {15'b0, v[a-8]};
        return 16'h0;
    endfunction

    function automatic string tag_of(int a);
        if (a == 0) return "R1";
        if (a == 1 || a == 2) return "R2";
        if (a == 3) return "R8";
        if (a == 4) return "R4";
        if (a == 10 || a == 12) return "R6";
        if (a >= 8 && a < 20) return "R3";
        return "R11";
    endfunction

    // One clock: drive the inputs, compare before the edge, advance the model after it.
    task automatic go(input bit [11:0] pulses, input bit [12:0] c, input bit we,
                      input bit [11:0] wd, input bit en, input int a);
        bit [11:0] v;
        bit        wipe;
        src = (pulses & ~12'h014) | level_bits;
        cause = c; mask_we = we; mask_wd = wd; rd_en = en; rd_addr = 5'(a);
        #4;
        checks++;
        if (rd_data !== exp_data(a)) begin
            errors++;
            $display("FAIL %s rd_data addr %0d got %h exp %h", tag_of(a), a, rd_data, exp_data(a));
        end
        checks++;
        if (irq !== m_irq) begin
            errors++;
            $display("FAIL R7 irq got %b exp %b", irq, m_irq);
        end
        @(posedge clk);
        v = view();
        m_irq = |(v & m_mask);
        for (int i = 0; i < 12; i++) begin
            if (!is_level(i)) begin
                if (src[i]) m_lat[i] = 1'b1;
                else if (en && (a == 4 || a == 8 + i)) m_lat[i] = 1'b0;
            end
        end
        if (we) m_mask = wd;
        wipe = en && (a == 4 || a == 14);
        if (wipe) m_cause = '0;
        for (int k = 0; k < 13; k++)
            if (c[k] && k != 6 && k != 8) m_cause[k] = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input int a);
        go(12'h0, 13'h0, 1'b0, 12'h0, 1'b1, a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state of raw, masked, mask, cause, and irq
        for (int a = 0; a < 5; a++) rd(a);
        // R1: each latched source individually, then raw read
        for (int i = 0; i < 12; i++) begin
            go(12'(1) << i, 13'h0, 1'b0, 12'h0, 1'b0, 0);
            rd(0);
        end
        // R2 and R7: mask write, masked read, interrupt follows
        go(12'h0, 13'h0, 1'b1, 12'hA5B, 1'b0, 0);
        rd(1); rd(2); rd(0);
        // R3: per-source clears, one at a time
        rd(8); rd(0); rd(9); rd(17); rd(0); rd(19); rd(1);
        // R4: set everything, then combined clear
        go(12'hFFF, 13'h0, 1'b0, 12'h0, 1'b0, 0);
        rd(4); rd(0); rd(1);
        // R5: event in the same cycle as its own clear or the combined clear
        go(12'h200, 13'h0, 1'b0, 12'h0, 1'b1, 17); rd(0);
        go(12'h001, 13'h0, 1'b0, 12'h0, 1'b1, 4); rd(0);
        // R6: level sources ignore clears
        level_bits = 12'h014;
        rd(0); rd(10); rd(12); rd(4); rd(0); rd(1);
        level_bits = 12'h0;
        rd(0);
        // R8: causes accumulate, reserved positions dropped
        go(12'h0, 13'h0001, 1'b0, 12'h0, 1'b0, 3);
        go(12'h0, 13'h1000, 1'b0, 12'h0, 1'b0, 3);
        go(12'h0, 13'h0140, 1'b0, 12'h0, 1'b0, 3);
        rd(3);
        go(12'h0, 13'h1FFF, 1'b0, 12'h0, 1'b0, 3);
        rd(3);
        // R9: abort clear wipes causes; same-cycle cause survives
        rd(14); rd(3);
        go(12'h040, 13'h0008, 1'b0, 12'h0, 1'b1, 14); rd(3);
        rd(4); rd(3);
        // R11: undecoded addresses
        go(12'h0F0, 13'h0002, 1'b0, 12'h0, 1'b0, 0);
        rd(5); rd(6); rd(7); rd(20); rd(31); rd(0); rd(3);
        // Mixed random traffic over all addresses
        for (int n = 0; n < 600; n++) begin
            bit [11:0] p = 12'($urandom) & 12'($urandom) & 12'($urandom);
            level_bits = 12'($urandom) & 12'h014;
            go(p, 13'($urandom) & 13'($urandom) & 13'($urandom),
               ($urandom % 16) == 0, 12'($urandom), ($urandom % 2) == 1, int'($urandom % 32));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule